// File: doc/BRIEF.md
# Receive Discard Control and Drop Counter

This block sits beside the receive path of an Ethernet MAC and handles two separate kinds of frame discard. Software can cancel the frame that is arriving now by writing a command bit. The command lasts only as long as that frame. If it is in place when the frame ends, the frame is dropped and the overrun/discard interrupt bit is set. If it comes too late, or no frame is active, the frame completes normally and the receive-complete bit is set.

Separately, an 8-bit counter records how many frames the datapath dropped because an external discard input was active. Reading the counter clears it. When it reaches its all-ones value it raises an alert interrupt bit. It wraps on the next increment and does not saturate.

The host reaches the block through a small synchronous register port. Read data is combinational from the address. Each interrupt status bit stays set until the host writes a 1 to that bit position.

Top module: `rx_discard_ctl`

Register map (address `host_addr`):
- 0 — command: writing 1 to bit 0 requests a discard. A read returns the pending command in bit 0.
- 1 — drop count: a read returns the count in bits 7:0 and clears it.
- 2 — interrupt status: bit 0 receive complete, bit 4 receive overrun/discard, bit 5 count alert. Writing 1 to a bit clears it.
- 3 — reads as 0.

## Requirements
- R1: Each clock cycle with `drop_pin_evt` high adds one to the drop count, which is read at address 1.
- R2: A read of address 1 returns the current count, and the count is 0 from the next cycle on.
- R3: A read of address 1 in the same cycle as an increment returns the old value, and the count then holds 1.
- R4: An increment from 0xFF gives 0x00. The count never saturates.
- R5: The increment that brings the count to 0xFF sets status bit 5 (`irq_cnt_alert`) on the next cycle.
- R6: Writing 1 to bit 0 of address 0 while a frame is in progress raises `discard_req` from the next cycle. If the command is still pending at `rx_end`, status bit 4 (`irq_rx_ovrn`) is set and bit 0 is not.
- R7: A frame whose `rx_end` arrives with no pending command sets status bit 0 (`irq_rx_done`). This includes a command written in the same cycle as `rx_end`.
- R8: The command clears itself once the frame it acted on ends. Address 0 then reads 0, and the next frame completes normally.
- R9: A command written while no frame is in progress reads back 0 two cycles after the write. It never raises `discard_req`, and the next frame completes normally.
- R10: A status bit stays set until the host writes 1 to its position at address 2. Writing 0 there leaves it set.
- R11: After reset the count is 0, all status bits are 0 and `discard_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_start | input | 1 | One-cycle strobe: a frame begins |
| rx_end | input | 1 | One-cycle strobe: the current frame ends |
| drop_pin_evt | input | 1 | One-cycle strobe per frame dropped by the external discard input |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (clears the count at address 1) |
| host_addr | input | 2 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, combinational from `host_addr` |
| discard_req | output | 1 | Drop request to the receive datapath for the current frame |
| irq_rx_done | output | 1 | Status bit 0: a frame completed normally |
| irq_rx_ovrn | output | 1 | Status bit 4: a frame was discarded |
| irq_cnt_alert | output | 1 | Status bit 5: the drop count reached 0xFF |

## Verification
The hardest case to reach is the counter rolling over. The count has to be brought to 0xFE without any read clearing it. Then the alert must be seen to appear on the step to 0xFF, and the wrap must be confirmed without a read that would hide it. The stimulus drives a burst of 254 drop strobes and checks only the status register at that point. It then adds one strobe and checks the alert, then adds two more and expects a count of 1. The race between a command write and `rx_end` in the same cycle is driven directly, and completion is checked afterwards.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
   localparam int unsigned REG_ADDR_W = 2;

   typedef enum logic [REG_ADDR_W-1:0] {
      REG_CMD   = 2'd0,
      REG_COUNT = 2'd1,
      REG_IRQ   = 2'd2,
      REG_NONE  = 2'd3
   } rxd_reg_e;

   localparam int unsigned IRQ_SRC_N = 3;
   localparam int unsigned SRC_DONE  = 0;
   localparam int unsigned SRC_OVRN  = 1;
   localparam int unsigned SRC_ALERT = 2;
endpackage

// File: rtl/rxd_drop_counter.sv
module rxd_drop_counter #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             rd_clr,
   output logic [CNT_W-1:0] count,
   output logic             alert_set
);
   localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
   localparam logic [CNT_W-1:0] CNT_FULL = {CNT_W{1'b1}};

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("rxd_drop_counter: CNT_W must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_nxt;

   always_comb begin
      cnt_nxt = count;
      if (rd_clr && inc)  cnt_nxt = CNT_ONE;
      else if (rd_clr)    cnt_nxt = '0;
      else if (inc)       cnt_nxt = count + CNT_ONE;
   end

   assign alert_set = inc && (cnt_nxt == CNT_FULL);

   always_ff @(posedge clk) begin
      if (!rst_n) count <= '0;
      else        count <= cnt_nxt;
   end

   assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !rd_clr) |=> (count == $past(count) + CNT_ONE));
   assert_clear_on_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr && !inc) |=> (count == '0));
   assert_read_race_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr && inc) |=> (count == CNT_ONE));
   assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !rd_clr && count == CNT_FULL) |=> (count == '0));
   assert_alert_at_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
      alert_set |=> (count == CNT_FULL));
endmodule

// File: rtl/rxd_discard_cmd.sv
module rxd_discard_cmd (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_start,
   input  logic rx_end,
   input  logic cmd_wr,
   output logic cmd_pend,
   output logic discard_req,
   output logic done_set,
   output logic ovrn_set
);
   logic in_frame;

   always_ff @(posedge clk) begin
      if (!rst_n)        in_frame <= 1'b0;
      else if (rx_start) in_frame <= 1'b1;
      else if (rx_end)   in_frame <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                     cmd_pend <= 1'b0;
      else if (cmd_wr)                cmd_pend <= 1'b1;
      else if (!in_frame || rx_end)   cmd_pend <= 1'b0;
   end

   assign discard_req = cmd_pend && in_frame;
   assign done_set    = rx_end && in_frame && !cmd_pend;
   assign ovrn_set    = rx_end && in_frame && cmd_pend;

   assert_one_outcome_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_set && ovrn_set));
   assert_self_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_end && !cmd_wr) |=> !cmd_pend);
   assert_idle_cmd_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_frame && !rx_start && !cmd_wr) |=> !cmd_pend);
   assert_req_needs_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
      discard_req |-> in_frame);
endmodule

// File: rtl/rxd_irq_bit.sv
module rxd_irq_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic ack,
   output logic q
);
   always_ff @(posedge clk) begin
      if (!rst_n)   q <= 1'b0;
      else if (set) q <= 1'b1;
      else if (ack) q <= 1'b0;
   end

   assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (q && !ack) |=> q);
   assert_ack_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !set) |=> !q);
   assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> q);
endmodule

// File: rtl/rx_discard_ctl.sv
module rx_discard_ctl #(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned CNT_W     = 8,
   parameter int unsigned DONE_POS  = 0,
   parameter int unsigned OVRN_POS  = 4,
   parameter int unsigned ALERT_POS = 5
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            rx_start,
   input  logic                            rx_end,
   input  logic                            drop_pin_evt,
   input  logic                            host_wr,
   input  logic                            host_rd,
   input  logic [rxd_pkg::REG_ADDR_W-1:0]  host_addr,
   input  logic [DATA_W-1:0]               host_wdata,
   output logic [DATA_W-1:0]               host_rdata,
   output logic                            discard_req,
   output logic                            irq_rx_done,
   output logic                            irq_rx_ovrn,
   output logic                            irq_cnt_alert
);
   import rxd_pkg::*;

   localparam int unsigned SRC_POS [IRQ_SRC_N] = '{DONE_POS, OVRN_POS, ALERT_POS};

   generate
      if (CNT_W > DATA_W) begin : g_bad_cnt
         $error("rx_discard_ctl: CNT_W must not exceed DATA_W");
      end
      if (DONE_POS >= DATA_W || OVRN_POS >= DATA_W || ALERT_POS >= DATA_W) begin : g_bad_pos
         $error("rx_discard_ctl: interrupt bit position outside DATA_W");
      end
      if (DONE_POS == OVRN_POS || DONE_POS == ALERT_POS || OVRN_POS == ALERT_POS) begin : g_dup_pos
         $error("rx_discard_ctl: interrupt bit positions must differ");
      end
   endgenerate

   rxd_reg_e reg_sel;
   assign reg_sel = rxd_reg_e'(host_addr);

   logic             cmd_wr, cnt_rd_clr, cmd_pend, done_set, ovrn_set, alert_set;
   logic [CNT_W-1:0] drop_count;
   logic [IRQ_SRC_N-1:0] irq_set, irq_ack, irq_q;

   assign cmd_wr     = host_wr && (reg_sel == REG_CMD) && host_wdata[0];
   assign cnt_rd_clr = host_rd && (reg_sel == REG_COUNT);

   rxd_discard_cmd u_cmd (
      .clk         (clk),
      .rst_n       (rst_n),
      .rx_start    (rx_start),
      .rx_end      (rx_end),
      .cmd_wr      (cmd_wr),
      .cmd_pend    (cmd_pend),
      .discard_req (discard_req),
      .done_set    (done_set),
      .ovrn_set    (ovrn_set)
   );

   rxd_drop_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .inc       (drop_pin_evt),
      .rd_clr    (cnt_rd_clr),
      .count     (drop_count),
      .alert_set (alert_set)
   );

   assign irq_set[SRC_DONE]  = done_set;
   assign irq_set[SRC_OVRN]  = ovrn_set;
   assign irq_set[SRC_ALERT] = alert_set;

   for (genvar g = 0; g < IRQ_SRC_N; g++) begin : g_irq
      assign irq_ack[g] = host_wr && (reg_sel == REG_IRQ) && host_wdata[SRC_POS[g]];
      rxd_irq_bit u_bit (
         .clk   (clk),
         .rst_n (rst_n),
         .set   (irq_set[g]),
         .ack   (irq_ack[g]),
         .q     (irq_q[g])
      );
   end

   assign irq_rx_done   = irq_q[SRC_DONE];
   assign irq_rx_ovrn   = irq_q[SRC_OVRN];
   assign irq_cnt_alert = irq_q[SRC_ALERT];

   logic [DATA_W-1:0] irq_word;
   always_comb begin
      irq_word = '0;
      for (int i = 0; i < IRQ_SRC_N; i++) irq_word[SRC_POS[i]] = irq_q[i];
   end

   always_comb begin
      host_rdata = '0;
      case (reg_sel)
         REG_CMD:   host_rdata[0] = cmd_pend;
         REG_COUNT: host_rdata[CNT_W-1:0] = drop_count;
         REG_IRQ:   host_rdata = irq_word;
         default:   host_rdata = '0;
      endcase
   end

   logic unused_wdata;
   assign unused_wdata = ^host_wdata;

   assert_reset_quiet_R11: assert property (@(posedge clk)
      !rst_n |=> (irq_q == '0 && !discard_req));
   assert_discard_steers_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_end && discard_req) |=> irq_rx_ovrn);
   assert_normal_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_set |=> (irq_rx_done && !discard_req));
endmodule

// File: tb/sim_rx_discard_ctl.sv
module sim_rx_discard_ctl;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_start = 1'b0, rx_end = 1'b0, drop_pin_evt = 1'b0;
   logic       host_wr = 1'b0, host_rd = 1'b0;
   logic [1:0] host_addr = 2'd0;
   logic [7:0] host_wdata = 8'd0;
   logic [7:0] host_rdata;
   logic       discard_req, irq_rx_done, irq_rx_ovrn, irq_cnt_alert;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   rx_discard_ctl u0 (
      .clk (clk), .rst_n (rst_n), .rx_start (rx_start), .rx_end (rx_end),
      .drop_pin_evt (drop_pin_evt), .host_wr (host_wr), .host_rd (host_rd),
      .host_addr (host_addr), .host_wdata (host_wdata), .host_rdata (host_rdata),
      .discard_req (discard_req), .irq_rx_done (irq_rx_done),
      .irq_rx_ovrn (irq_rx_ovrn), .irq_cnt_alert (irq_cnt_alert)
   );

   // monitor: pops one expected read value per read cycle
   always @(negedge clk) begin
      if (host_rd && !finished) begin
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL unexpected read: actual %02h expected none", host_rdata);
         end else begin
            automatic logic [7:0] e = exp_q.pop_front();
            automatic string      t = tag_q.pop_front();
            if (host_rdata !== e) begin
               errors++;
               $display("FAIL %s: actual %02h expected %02h", t, host_rdata, e);
            end
         end
      end
   end

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic reg_read(input logic [1:0] a, input logic [7:0] e, input string t);
      exp_q.push_back(e);
      tag_q.push_back(t);
      host_rd = 1'b1; host_addr = a;
      tick();
      host_rd = 1'b0;
   endtask

   task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
      host_wr = 1'b1; host_addr = a; host_wdata = d;
      tick();
      host_wr = 1'b0; host_wdata = 8'd0;
   endtask

   task automatic check_bit(input logic act, input logic e, input string t);
      checks++;
      if (act !== e) begin
         errors++;
         $display("FAIL %s: actual %0b expected %0b", t, act, e);
      end
   endtask

   task automatic drops(input int n);
      drop_pin_evt = 1'b1;
      repeat (n) tick();
      drop_pin_evt = 1'b0;
   endtask

   task automatic pulse_start();
      rx_start = 1'b1; tick(); rx_start = 1'b0;
   endtask

   task automatic pulse_end();
      rx_end = 1'b1; tick(); rx_end = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R11 reset state
      check_bit(discard_req, 1'b0, "R11 discard_req after reset");
      check_bit(irq_cnt_alert, 1'b0, "R11 alert after reset");
      reg_read(2'd1, 8'h00, "R11 count after reset");
      reg_read(2'd2, 8'h00, "R11 status after reset");

      // R1 counting, R2 clear on read
      drops(5);
      reg_read(2'd1, 8'h05, "R1 count after five drops");
      reg_read(2'd1, 8'h00, "R2 count after read");

      // R3 read racing an increment
      drops(3);
      drop_pin_evt = 1'b1;
      reg_read(2'd1, 8'h03, "R3 read during increment returns old");
      drop_pin_evt = 1'b0;
      reg_read(2'd1, 8'h01, "R3 count holds one after race");

      // R5 alert, R4 wrap, R10 sticky
      drops(254);
      reg_read(2'd2, 8'h00, "R5 no alert at 0xFE");
      drops(1);
      reg_read(2'd2, 8'h20, "R5 alert at 0xFF");
      check_bit(irq_cnt_alert, 1'b1, "R5 alert pin");
      drops(2);
      reg_read(2'd1, 8'h01, "R4 wrap past 0xFF");
      reg_write(2'd2, 8'h00);
      reg_read(2'd2, 8'h20, "R10 write of zero keeps bit");
      reg_write(2'd2, 8'h20);
      reg_read(2'd2, 8'h00, "R10 write of one clears bit");

      // R7 normal frame
      pulse_start(); tick(); tick();
      pulse_end();
      reg_read(2'd2, 8'h01, "R7 normal completion");
      check_bit(irq_rx_done, 1'b1, "R7 done pin");
      reg_write(2'd2, 8'h01);

      // R6 discard during frame
      pulse_start();
      reg_write(2'd0, 8'h01);
      check_bit(discard_req, 1'b1, "R6 discard_req raised");
      reg_read(2'd0, 8'h01, "R6 command pending");
      pulse_end();
      check_bit(discard_req, 1'b0, "R6 discard_req dropped after end");
      reg_read(2'd2, 8'h10, "R6 overrun bit only");
      check_bit(irq_rx_ovrn, 1'b1, "R6 overrun pin");
      // R8 self clear
      reg_read(2'd0, 8'h00, "R8 command cleared");
      reg_write(2'd2, 8'h10);
      pulse_start();
      check_bit(discard_req, 1'b0, "R8 next frame not discarded");
      pulse_end();
      reg_read(2'd2, 8'h01, "R8 next frame completes");
      reg_write(2'd2, 8'h01);

      // R7 late command at rx_end
      pulse_start(); tick();
      host_wr = 1'b1; host_addr = 2'd0; host_wdata = 8'h01; rx_end = 1'b1;
      tick();
      host_wr = 1'b0; host_wdata = 8'h00; rx_end = 1'b0;
      reg_read(2'd2, 8'h01, "R7 late command completes normally");
      tick();
      reg_read(2'd0, 8'h00, "R7 late command gone");
      reg_write(2'd2, 8'h01);

      // R9 command while idle
      reg_write(2'd0, 8'h01);
      check_bit(discard_req, 1'b0, "R9 no discard_req when idle");
      tick();
      reg_read(2'd0, 8'h00, "R9 idle command cleared");
      pulse_start();
      check_bit(discard_req, 1'b0, "R9 next frame not discarded");
      pulse_end();
      reg_read(2'd2, 8'h01, "R9 next frame completes");

      tick(); tick();
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule